// File: doc/BRIEF.md
# Bridge Window Configuration Register File

This block holds the software-visible setup of a bus-to-memory bridge: a set of address windows, each described by a base register, a mask register and a translated-base register, plus one bridge control word. All registers are 64 bits wide. They sit on a 64-byte stride above a fixed base address, and only full 64-bit accesses are accepted. The register contents are driven out in parallel so that a neighbouring address translator always sees the current window setup.

Accesses arrive on a valid/ready request channel and are answered one cycle later on a response channel that carries read data and an error flag. A two-state controller runs each access. In `S_IDLE` the block is ready. The transition *accept* (request valid while idle) performs the write, latches the read data and error, and enters `S_RESP`. In `S_RESP` the response is presented. The transition *release* (response ready) returns to `S_IDLE`, and the response is held for as long as the ready is low. Some offsets read as zero or discard writes. Unimplemented or undefined offsets return an error. A write to the cache-invalidate offset also produces a one-cycle pulse.

Top module: `bridge_window_regs`

## Requirements
- R1: The register index is (req_addr − BASE_ADDR) >> 6, so address bits 5:0 are ignored. An address below BASE_ADDR, or one whose index does not fit IDX_W bits, gets an error response.
- R2: req_size encodes the access width: 3 = 64-bit, 2 = 32-bit, 1 = 16-bit, 0 = 8-bit. Any size other than 3 gets an error response, read data of zero, and no register change.
- R3: Indices 0..NWIN-1 hold the window bases, NWIN..2·NWIN-1 the window masks and 2·NWIN..3·NWIN-1 the translated bases. All reset to zero, and each reads back the last value written to it.
- R4: The control register at index 3·NWIN (12 by default) resets to 64'h0000_0021_0010_0000 (bit 20 set, bit 32 set, value 2 in bits 39:36) and is read/write.
- R5: The error-status offset (index 3·NWIN+3) reads zero without error. A write to it completes without error and changes nothing.
- R6: The error-mask offset (index 3·NWIN+4) reads zero without error. A write to it returns an error.
- R7: The invalidate-all offset (index 3·NWIN+7) reads zero without error. A write completes without error, stores nothing, and raises inval_pulse for exactly one cycle, in the cycle the response is valid.
- R8: The unimplemented offsets 3·NWIN+1, +2, +5, +6, +8, +9, and every index at or above 3·NWIN+10, return an error with read data zero. Writes to them change nothing.
- R9: req_ready is high only in S_IDLE. A request accepted at one clock edge is answered with rsp_valid after that edge. rsp_valid, rsp_rdata and rsp_error stay stable until rsp_ready is seen.
- R10: win_base_o, win_mask_o, xlat_base_o and ctrl_o show a written value from the cycle after the accepting edge. Window n occupies bits 64n+63:64n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access width code (3 = 64-bit) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 64 | Read data (zero on error) |
| rsp_error | output | 1 | Access was illegal |
| win_base_o | output | NWIN*64 | All window base registers |
| win_mask_o | output | NWIN*64 | All window mask registers |
| xlat_base_o | output | NWIN*64 | All translated base registers |
| ctrl_o | output | 64 | Bridge control register |
| inval_pulse | output | 1 | One-cycle pulse on a write to invalidate-all |

## Verification
The bench writes a distinct pattern to every window register and reads each one back. A decoder that is off by one group, or that aliases windows, would therefore return a neighbour's value or put it in the wrong output lane. It sends narrow writes, writes below the base, writes to each unimplemented offset and a write to the error mask at the control register or at neighbouring live offsets, and then rereads that state. A design that lets an erroneous access fall through to storage would show a changed control word. The invalidate pulse is checked to be present for exactly one cycle and only for a write. The response is held under back-pressure to catch a controller that drops or reissues it early.

// File: rtl/brw_pkg.sv
package brw_pkg;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } brw_state_e;

    typedef enum logic [2:0] {
        K_WBASE    = 3'd0,
        K_WMASK    = 3'd1,
        K_XBASE    = 3'd2,
        K_CTRL     = 3'd3,
        K_RAZ_WI   = 3'd4,
        K_RAZ_WERR = 3'd5,
        K_INVAL    = 3'd6,
        K_BAD      = 3'd7
    } brw_kind_e;

    localparam logic [1:0]  SZ_64      = 2'd3;
    localparam logic [63:0] CTRL_RESET = (64'd1 << 20) | (64'd1 << 32) | (64'd2 << 36);

endpackage

// File: rtl/brw_decode.sv
module brw_decode
    import brw_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int              NWIN      = 4,
    parameter int              IDX_W     = 8,
    localparam int             SEL_W     = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              write,
    output brw_kind_e         kind,
    output logic [SEL_W-1:0]  sel,
    output logic              err
);
    localparam int MASK_IDX  = NWIN;
    localparam int XBASE_IDX = 2 * NWIN;
    localparam int CTRL_IDX  = 3 * NWIN;
    localparam int ESTAT_IDX = CTRL_IDX + 3;
    localparam int EMASK_IDX = CTRL_IDX + 4;
    localparam int INVAL_IDX = CTRL_IDX + 7;

    logic [ADDR_W-1:0] off;
    logic              out_of_range;
    int                idx;
    int                rel;

    assign off          = addr - BASE_ADDR;
    assign out_of_range = (addr < BASE_ADDR) || (|off[ADDR_W-1:IDX_W+6]);
    assign idx          = int'(off[IDX_W+5:6]);

    always_comb begin
        kind = K_BAD;
        rel  = 0;
        if (out_of_range) begin
            kind = K_BAD;
        end else if (idx < MASK_IDX) begin
            kind = K_WBASE;
            rel  = idx;
        end else if (idx < XBASE_IDX) begin
            kind = K_WMASK;
            rel  = idx - MASK_IDX;
        end else if (idx < CTRL_IDX) begin
            kind = K_XBASE;
            rel  = idx - XBASE_IDX;
        end else if (idx == CTRL_IDX) begin
            kind = K_CTRL;
        end else if (idx == ESTAT_IDX) begin
            kind = K_RAZ_WI;
        end else if (idx == EMASK_IDX) begin
            kind = K_RAZ_WERR;
        end else if (idx == INVAL_IDX) begin
            kind = K_INVAL;
        end
        sel = rel[SEL_W-1:0];
    end

    assign err = (size != SZ_64) || (kind == K_BAD) || ((kind == K_RAZ_WERR) && write);

endmodule

// File: rtl/brw_regbank.sv
module brw_regbank
    import brw_pkg::*;
#(
    parameter  int NWIN  = 4,
    localparam int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  brw_kind_e          kind,
    input  logic [SEL_W-1:0]   sel,
    input  logic [63:0]        wdata,
    output logic [63:0]        rdata,
    output logic [NWIN*64-1:0] win_base_o,
    output logic [NWIN*64-1:0] win_mask_o,
    output logic [NWIN*64-1:0] xlat_base_o,
    output logic [63:0]        ctrl_o
);
    logic [63:0] wbase_q [NWIN];
    logic [63:0] wmask_q [NWIN];
    logic [63:0] xbase_q [NWIN];
    logic [63:0] ctrl_q;

    for (genvar n = 0; n < NWIN; n++) begin : g_win
        logic hit;
        assign hit = we && (int'(sel) == n);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wbase_q[n] <= '0;
                wmask_q[n] <= '0;
                xbase_q[n] <= '0;
            end else if (hit) begin
                unique case (kind)
                    K_WBASE: wbase_q[n] <= wdata;
                    K_WMASK: wmask_q[n] <= wdata;
                    K_XBASE: xbase_q[n] <= wdata;
                    default: ;
                endcase
            end
        end

        assign win_base_o[n*64 +: 64]  = wbase_q[n];
        assign win_mask_o[n*64 +: 64]  = wmask_q[n];
        assign xlat_base_o[n*64 +: 64] = xbase_q[n];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (we && (kind == K_CTRL)) begin
            ctrl_q <= wdata;
        end
    end

    assign ctrl_o = ctrl_q;

    always_comb begin
        unique case (kind)
            K_WBASE: rdata = wbase_q[sel];
            K_WMASK: rdata = wmask_q[sel];
            K_XBASE: rdata = xbase_q[sel];
            K_CTRL:  rdata = ctrl_q;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/bridge_window_regs.sv
module bridge_window_regs
    import brw_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1000_0000,
    parameter int                NWIN      = 4,
    parameter int                IDX_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    input  logic [63:0]        req_wdata,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [63:0]        rsp_rdata,
    output logic               rsp_error,
    output logic [NWIN*64-1:0] win_base_o,
    output logic [NWIN*64-1:0] win_mask_o,
    output logic [NWIN*64-1:0] xlat_base_o,
    output logic [63:0]        ctrl_o,
    output logic               inval_pulse
);
    localparam int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1;

    brw_state_e       state_q, state_d;
    brw_kind_e        kind;
    logic [SEL_W-1:0] sel;
    logic             dec_err;
    logic             accept;
    logic             bank_we;
    logic [63:0]      bank_rdata;
    logic [63:0]      rdata_q;
    logic             err_q;
    logic             inval_q;

    brw_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .NWIN      (NWIN),
        .IDX_W     (IDX_W)
    ) u_dec (
        .addr  (req_addr),
        .size  (req_size),
        .write (req_write),
        .kind  (kind),
        .sel   (sel),
        .err   (dec_err)
    );

    assign accept  = req_valid && (state_q == S_IDLE);
    assign bank_we = accept && req_write && !dec_err;

    brw_regbank #(
        .NWIN (NWIN)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (bank_we),
        .kind        (kind),
        .sel         (sel),
        .wdata       (req_wdata),
        .rdata       (bank_rdata),
        .win_base_o  (win_base_o),
        .win_mask_o  (win_mask_o),
        .xlat_base_o (xlat_base_o),
        .ctrl_o      (ctrl_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_RESP;
            S_RESP:  if (rsp_ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
            inval_q <= 1'b0;
        end else begin
            inval_q <= bank_we && (kind == K_INVAL);
            if (accept) begin
                rdata_q <= (dec_err || req_write) ? 64'd0 : bank_rdata;
                err_q   <= dec_err;
            end
        end
    end

    always_comb begin
        req_ready   = 1'b0;
        rsp_valid   = 1'b0;
        unique case (state_q)
            S_IDLE: req_ready = 1'b1;
            S_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
        rsp_rdata   = rdata_q;
        rsp_error   = err_q;
        inval_pulse = inval_q;
    end

    // R9
    accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_error)));

    // R9
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    // R7
    inval_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval_pulse |=> !inval_pulse);

    // R2
    bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_size != SZ_64)) |=> rsp_error);

    // R2
    bad_size_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_size != SZ_64)) |=> ($stable(ctrl_o) && $stable(win_base_o)));

endmodule

// File: tb/sim_bridge_window_regs.sv
module sim_bridge_window_regs;
    localparam int          NWIN  = 4;
    localparam logic [31:0] BASE  = 32'h1000_0000;
    localparam logic [63:0] CTRL0 = 64'h0000_0021_0010_0000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic               req_write = 1'b0;
    logic [31:0]        req_addr = '0;
    logic [1:0]         req_size = 2'd3;
    logic [63:0]        req_wdata = '0;
    logic               rsp_valid;
    logic               rsp_ready = 1'b1;
    logic [63:0]        rsp_rdata;
    logic               rsp_error;
    logic [NWIN*64-1:0] win_base_o, win_mask_o, xlat_base_o;
    logic [63:0]        ctrl_o;
    logic               inval_pulse;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    bridge_window_regs #(.BASE_ADDR(BASE), .NWIN(NWIN)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .rsp_error(rsp_error), .win_base_o(win_base_o), .win_mask_o(win_mask_o),
        .xlat_base_o(xlat_base_o), .ctrl_o(ctrl_o), .inval_pulse(inval_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ra(input int idx);
        return BASE + 32'(idx * 64);
    endfunction

    function automatic logic [63:0] pat(input int i);
        return 64'hC3A5_0F00_1234_5678 ^ (64'(i + 1) * 64'h0101_0011_0100_1001);
    endfunction

    task automatic acc(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                       input logic [63:0] wd, output logic [63:0] rd, output logic er,
                       output logic pl);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R9 response after accept", 64'(rsp_valid), 64'd1);
        rd = rsp_rdata; er = rsp_error; pl = inval_pulse;
    endtask

    task automatic t_reset();
        logic [63:0] rd; logic er, pl;
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R9 idle after reset", {req_ready, rsp_valid}, 2'b10);
        chk(ctrl_o === CTRL0, "R4 control reset output", ctrl_o, CTRL0);
        chk(win_base_o === '0 && win_mask_o === '0 && xlat_base_o === '0, "R3 windows reset",
            win_base_o[63:0] | win_mask_o[63:0] | xlat_base_o[63:0], 64'd0);
        acc(1'b0, ra(12), 2'd3, '0, rd, er, pl);
        chk(rd === CTRL0 && !er, "R4 control reset read", rd, CTRL0);
        for (int i = 0; i < 12; i++) begin
            acc(1'b0, ra(i), 2'd3, '0, rd, er, pl);
            chk(rd === 64'd0 && !er, "R3 register reset read", rd, 64'd0);
        end
    endtask

    task automatic t_windows();
        logic [63:0] rd; logic er, pl;
        for (int i = 0; i < 12; i++) begin
            acc(1'b1, ra(i), 2'd3, pat(i), rd, er, pl);
            chk(!er, "R3 window write accepted", 64'(er), 64'd0);
        end
        for (int i = 0; i < 12; i++) begin
            acc(1'b0, ra(i), 2'd3, '0, rd, er, pl);
            chk(rd === pat(i) && !er, "R3 window readback", rd, pat(i));
        end
        for (int n = 0; n < NWIN; n++) begin
            chk(win_base_o[n*64 +: 64] === pat(n), "R10 base lane", win_base_o[n*64 +: 64], pat(n));
            chk(win_mask_o[n*64 +: 64] === pat(n + 4), "R10 mask lane", win_mask_o[n*64 +: 64], pat(n + 4));
            chk(xlat_base_o[n*64 +: 64] === pat(n + 8), "R10 xlat lane", xlat_base_o[n*64 +: 64], pat(n + 8));
        end
    endtask

    task automatic t_ctrl();
        logic [63:0] rd; logic er, pl;
        acc(1'b1, ra(12), 2'd3, 64'hFEED_0000_BEEF_0001, rd, er, pl);
        chk(ctrl_o === 64'hFEED_0000_BEEF_0001 && !er, "R10 control output after write", ctrl_o, 64'hFEED_0000_BEEF_0001);
        acc(1'b0, ra(12) + 32'd40, 2'd3, '0, rd, er, pl);
        chk(rd === 64'hFEED_0000_BEEF_0001, "R1 low address bits ignored", rd, 64'hFEED_0000_BEEF_0001);
        acc(1'b1, ra(12) + 32'd8, 2'd3, CTRL0, rd, er, pl);
        chk(ctrl_o === CTRL0, "R4 control rewrite", ctrl_o, CTRL0);
    endtask

    task automatic t_sizes();
        logic [63:0] rd; logic er, pl;
        for (int s = 0; s < 3; s++) begin
            acc(1'b1, ra(12), 2'(s), 64'h1111_2222_3333_4444, rd, er, pl);
            chk(er === 1'b1, "R2 narrow write error", 64'(er), 64'd1);
            acc(1'b0, ra(0), 2'(s), '0, rd, er, pl);
            chk(er === 1'b1 && rd === 64'd0, "R2 narrow read error", rd, 64'd0);
        end
        chk(ctrl_o === CTRL0, "R2 narrow write no effect", ctrl_o, CTRL0);
    endtask

    task automatic t_raz();
        logic [63:0] rd; logic er, pl;
        acc(1'b1, ra(15), 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, rd, er, pl);
        chk(!er, "R5 error status write ok", 64'(er), 64'd0);
        acc(1'b0, ra(15), 2'd3, '0, rd, er, pl);
        chk(rd === 64'd0 && !er, "R5 error status reads zero", rd, 64'd0);
        chk(ctrl_o === CTRL0 && win_base_o[63:0] === pat(0), "R5 write no effect", ctrl_o, CTRL0);
        acc(1'b0, ra(16), 2'd3, '0, rd, er, pl);
        chk(rd === 64'd0 && !er, "R6 error mask reads zero", rd, 64'd0);
        acc(1'b1, ra(16), 2'd3, 64'h5, rd, er, pl);
        chk(er === 1'b1, "R6 error mask write error", 64'(er), 64'd1);
        chk(ctrl_o === CTRL0, "R6 write no effect", ctrl_o, CTRL0);
    endtask

    task automatic t_inval();
        logic [63:0] rd; logic er, pl;
        acc(1'b1, ra(19), 2'd3, 64'hABCD, rd, er, pl);
        chk(!er && pl === 1'b1, "R7 invalidate pulse on write", {er, pl}, 2'b01);
        @(negedge clk);
        chk(inval_pulse === 1'b0, "R7 pulse lasts one cycle", 64'(inval_pulse), 64'd0);
        acc(1'b0, ra(19), 2'd3, '0, rd, er, pl);
        chk(rd === 64'd0 && !er && pl === 1'b0, "R7 read zero no pulse", rd, 64'd0);
        acc(1'b1, ra(19), 2'd1, 64'hABCD, rd, er, pl);
        chk(er === 1'b1 && pl === 1'b0, "R7 no pulse on bad size", {er, pl}, 2'b10);
    endtask

    task automatic t_unimpl();
        logic [63:0] rd; logic er, pl;
        int bad [9] = '{13, 14, 17, 18, 20, 21, 22, 100, 255};
        foreach (bad[k]) begin
            acc(1'b1, ra(bad[k]), 2'd3, 64'h7777, rd, er, pl);
            chk(er === 1'b1, "R8 unimplemented write error", 64'(er), 64'd1);
            acc(1'b0, ra(bad[k]), 2'd3, '0, rd, er, pl);
            chk(er === 1'b1 && rd === 64'd0, "R8 unimplemented read error", rd, 64'd0);
        end
        chk(ctrl_o === CTRL0 && win_base_o[63:0] === pat(0), "R8 writes no effect", ctrl_o, CTRL0);
        acc(1'b1, BASE - 32'd64, 2'd3, 64'h9, rd, er, pl);
        chk(er === 1'b1, "R1 below base error", 64'(er), 64'd1);
        acc(1'b0, ra(256), 2'd3, '0, rd, er, pl);
        chk(er === 1'b1, "R1 index overflow error", 64'(er), 64'd1);
        acc(1'b0, ra(256) + ra(0) - BASE, 2'd3, '0, rd, er, pl);
        chk(er === 1'b1, "R1 no aliasing above index range", 64'(er), 64'd1);
    endtask

    task automatic t_backpressure();
        logic [63:0] held;
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = ra(3); req_size = 2'd3;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        held = rsp_rdata;
        chk(held === pat(3), "R9 read data under back-pressure", held, pat(3));
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(rsp_valid === 1'b1 && req_ready === 1'b0 && rsp_rdata === held,
                "R9 response held", rsp_rdata, held);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R9 release to idle", {rsp_valid, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_windows();
        t_ctrl();
        t_sizes();
        t_raz();
        t_inval();
        t_unimpl();
        t_backpressure();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule